// File: doc/BRIEF.md
# I2C Target Status and Interrupt Logic

This block watches an already synchronized I2C clock and data pair and keeps the event flags that a target-side I2C controller reports to software. It finds START, repeated START and STOP conditions, counts the clock pulses of each byte, and shifts in the first byte after a START. It then compares the upper seven bits of that byte with a programmed target address, and can also accept the all-zero general call address.

The events that can be flagged are:

- completion of a byte
- a matching address, together with the direction bit it carried
- lost arbitration
- the two timeout conditions, which arrive as single-cycle pulses
- a wakeup match while the chip is in stop mode

Software clears a flag by writing 1 to its bit. One level-sensitive interrupt output is the OR of every pending flag whose enables are set.

Software programs the block through a small write port with three targets, selected by `wr_sel`:

- 0 is the control register: bit0 global interrupt enable, bit1 fast-acknowledge, bit2 general-call enable, bit3 wakeup enable, bit4 high-timeout enable.
- 1 is the 7-bit target address, in `wr_data[6:0]`.
- 2 is the write-one-to-clear port for the status flags.

The status word is always visible on `status_o`.

Top module: `i2c_tgt_status`

## Requirements
- R1: After reset, `status_o` is 8'h00 and `irq_o` is 0.
- R2: With fast-acknowledge off, status bit0 (byte done) sets one clock after the falling SCL edge of the ninth clock since the last START. It is still 0 after the eighth falling edge.
- R3: With fast-acknowledge on (control bit1), bit0 sets one clock after the eighth falling SCL edge. The ninth falling edge does not set it again.
- R4: When bits [7:1] of the first byte after a START equal the target address, status bit1 (addressed) sets one clock after the eighth falling SCL edge. At the same time, status bit2 takes that byte's bit0 (1 = read).
- R5: A first byte of 8'h00 sets bit1 only while general-call enable (control bit2) is 1.
- R6: A first byte that does not match leaves bit1 and bit2 unchanged. Data bytes are never compared.
- R7: Writing `wr_sel`=2 clears each flag in bits 0,1,3,4,5,6 whose `wr_data` bit is 1. Bits written 0 are kept, bit2 is never cleared by a write, and bit7 always reads 0.
- R8: `irq_o` is 1 exactly when control bit0 is 1 and any of status bits 0,1,3,4 is set, or a gated source in R9/R10 is pending. It stays 1 until those flags are cleared.
- R9: A pulse on `tmo_high_i` sets status bit5. That flag reaches `irq_o` only when control bit4 is also 1.
- R10: While `stop_mode_i` is 1, an address match (as in R4/R5) also sets status bit6. That flag reaches `irq_o` only when control bit3 is also 1.
- R11: A START or repeated START restarts the byte count, so the next byte is treated as a fresh address byte.
- R12: A pulse on `arb_lost_i` sets status bit3 and a pulse on `tmo_low_i` sets status bit4, one clock later. If a set and a clear meet in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| stop_mode_i | input | 1 | Chip is in stop mode |
| arb_lost_i | input | 1 | Arbitration-lost event pulse |
| tmo_low_i | input | 1 | SCL-low timeout event pulse |
| tmo_high_i | input | 1 | SCL-high/SDA-low timeout event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 address, 2 status clear |
| wr_data | input | 8 | Write data |
| status_o | output | 8 | Status flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A bit counter that has drifted moves bit0 to the wrong falling edge, and this shows on `status_o` one clock after that edge. A stale shift register or start detector makes bit1 and bit2 disagree with the byte just sent, one clock after the eighth falling edge of the address byte. A flag register that does not respond to clearing, or a wrong enable term, shows on `irq_o` in the cycle after the write or the pulse. A bench model that predicts `status_o` and `irq_o` every cycle therefore catches these faults within one clock of their cause.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int STAT_W   = 8;
  localparam int B_DONE   = 0;
  localparam int B_HIT    = 1;
  localparam int B_RW     = 2;
  localparam int B_ARB    = 3;
  localparam int B_LOWTMO = 4;
  localparam int B_HITMO  = 5;
  localparam int B_WAKE   = 6;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;

  typedef struct packed {
    logic shien;
    logic wken;
    logic gcen;
    logic fack;
    logic ien;
  } ctrl_t;

  // true when a first byte addresses this target
  function automatic logic addr_match(input logic [7:0] cb, input logic [6:0] own,
                                      input logic gcen);
    return (cb[7:1] == own) || (gcen && (cb == 8'h00));
  endfunction

  // clock number whose falling edge marks the end of a byte
  function automatic int unsigned done_clock(input logic fack, input int unsigned bits);
    return fack ? bits : bits + 1;
  endfunction
endpackage

// File: rtl/i2c_line_edges.sv
module i2c_line_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_byte_track.sv
module i2c_byte_track
  import i2c_tgt_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  parameter int ADDR_W    = 7,
  localparam int CNT_W    = $clog2(BYTE_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gcen,
  input  logic              fack,
  output logic              done_evt,
  output logic              addr_evt,
  output logic              rw_bit,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_CLK = CNT_W'(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] DATA_CLK = CNT_W'(BYTE_BITS);

  logic [BYTE_BITS-1:0] shreg;
  logic                 first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      first_q <= 1'b0;
    end else begin
      if (start_det || stop_det) begin
        bit_cnt <= '0;
        first_q <= start_det;
      end else if (scl_rise && bit_cnt < LAST_CLK) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < DATA_CLK) shreg <= {shreg[BYTE_BITS-2:0], sda_i};
      end else if (scl_fall && bit_cnt == LAST_CLK) begin
        bit_cnt <= '0;
        first_q <= 1'b0;
      end
    end
  end

  assign done_evt = scl_fall && (bit_cnt == CNT_W'(done_clock(fack, BYTE_BITS)));
  assign addr_evt = scl_fall && first_q && (bit_cnt == DATA_CLK) &&
                    addr_match(shreg[7:0], own_addr[6:0], gcen);
  assign rw_bit   = shreg[0];
endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  input  logic              rw_load,
  input  logic              rw_val,
  input  ctrl_t             ctrl,
  output logic [STAT_W-1:0] flags,
  output logic              irq
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i == B_RW) begin : g_rw
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       flags[i] <= 1'b0;
        else if (rw_load) flags[i] <= rw_val;
    end else if (i > B_WAKE) begin : g_rsvd
      assign flags[i] = 1'b0;
    end else begin : g_w1c
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= set_vec[i] | (flags[i] & ~clr_vec[i]);
    end
  end

  assign irq = ctrl.ien & (flags[B_DONE] | flags[B_HIT] | flags[B_ARB] | flags[B_LOWTMO] |
                           (ctrl.shien & flags[B_HITMO]) | (ctrl.wken & flags[B_WAKE]));
endmodule

// File: rtl/i2c_tgt_status.sv
module i2c_tgt_status
  import i2c_tgt_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  parameter int ADDR_W    = 7,
  localparam int CNT_W    = $clog2(BYTE_BITS + 2)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        stop_mode_i,
  input  logic        arb_lost_i,
  input  logic        tmo_low_i,
  input  logic        tmo_high_i,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [7:0]  wr_data,
  output logic [7:0]  status_o,
  output logic        irq_o
);
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] own_q;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic done_evt, addr_evt, rw_bit;
  logic [CNT_W-1:0]  bit_cnt;
  logic [STAT_W-1:0] set_vec, clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      own_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_CTRL) ctrl_q <= ctrl_t'(wr_data[4:0]);
      if (wr_sel == SEL_ADDR) own_q  <= wr_data[ADDR_W-1:0];
    end
  end

  i2c_line_edges u_edges (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_evt), .stop_det(stop_evt)
  );

  i2c_byte_track #(.BYTE_BITS(BYTE_BITS), .ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_evt), .stop_det(stop_evt), .own_addr(own_q), .gcen(ctrl_q.gcen),
    .fack(ctrl_q.fack), .done_evt(done_evt), .addr_evt(addr_evt), .rw_bit(rw_bit),
    .bit_cnt(bit_cnt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_DONE]   = done_evt;
    set_vec[B_HIT]    = addr_evt;
    set_vec[B_ARB]    = arb_lost_i;
    set_vec[B_LOWTMO] = tmo_low_i;
    set_vec[B_HITMO]  = tmo_high_i;
    set_vec[B_WAKE]   = addr_evt & stop_mode_i;
  end

  assign clr_vec = (wr_en && wr_sel == SEL_CLR) ? wr_data : '0;

  i2c_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .rw_load(addr_evt), .rw_val(rw_bit), .ctrl(ctrl_q), .flags(status_o), .irq(irq_o)
  );
endmodule

// File: rtl/i2c_tgt_status_chk.sv
module i2c_tgt_status_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       status_o,
  input logic             irq_o,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [7:0]       wr_data,
  input logic             arb_lost_i,
  input logic             done_evt,
  input logic             addr_evt,
  input logic             start_evt,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             ien
);
  assert_done_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(done_evt));

  assert_hit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(addr_evt));

  assert_w1c_arb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && wr_data[3] && !arb_lost_i) |=> !status_o[3]);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ien);

  assert_restart_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (bit_cnt == '0));

  assert_arb_sets_R12: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_i |=> status_o[3]);
endmodule

bind i2c_tgt_status i2c_tgt_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_o(status_o), .irq_o(irq_o), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .arb_lost_i(arb_lost_i), .done_evt(done_evt),
  .addr_evt(addr_evt), .start_evt(start_evt), .bit_cnt(bit_cnt), .ien(ctrl_q.ien)
);

// File: tb/tb_i2c_tgt_status.sv
module tb_i2c_tgt_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, stop_mode_i = 1'b0;
  logic arb_lost_i = 1'b0, tmo_low_i = 1'b0, tmo_high_i = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] status_o;
  logic irq_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  i2c_tgt_status dut (.*);

  always #2.5 clk = ~clk;

  // behavioural reference model
  int m_scl = 1, m_sda = 1, m_cnt = 0, m_byte = 0, m_first = 0;
  int m_ctrl = 0, m_own = 0, m_rw = 0;
  int m_flag[7];

  function automatic int model_status();
    int s = 0;
    for (int i = 0; i < 7; i++) if (i != 2 && m_flag[i] != 0) s += (1 << i);
    return s + (m_rw << 2);
  endfunction

  function automatic int model_irq();
    if ((m_ctrl & 1) == 0) return 0;
    if (m_flag[0] + m_flag[1] + m_flag[3] + m_flag[4] != 0) return 1;
    if ((m_ctrl & 16) != 0 && m_flag[5] != 0) return 1;
    if ((m_ctrl & 8) != 0 && m_flag[6] != 0) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_scl = 1; m_sda = 1; m_cnt = 0; m_byte = 0; m_first = 0;
      m_ctrl = 0; m_own = 0; m_rw = 0;
      for (int i = 0; i < 7; i++) m_flag[i] = 0;
    end else begin
      int sc, sd, clr, ends_at;
      int ev[7];
      bit rise, fall, st, sp, hit;
      sc = int'(scl_i); sd = int'(sda_i);
      rise = (sc == 1 && m_scl == 0);
      fall = (sc == 0 && m_scl == 1);
      st   = (sc == 1 && m_scl == 1 && m_sda == 1 && sd == 0);
      sp   = (sc == 1 && m_scl == 1 && m_sda == 0 && sd == 1);
      ends_at = ((m_ctrl & 2) != 0) ? 8 : 9;
      hit = fall && m_first == 1 && m_cnt == 8 &&
            (((m_byte >> 1) == m_own) || ((m_ctrl & 4) != 0 && m_byte == 0));
      for (int i = 0; i < 7; i++) ev[i] = 0;
      ev[0] = (fall && m_cnt == ends_at) ? 1 : 0;
      ev[1] = hit ? 1 : 0;
      ev[3] = int'(arb_lost_i); ev[4] = int'(tmo_low_i); ev[5] = int'(tmo_high_i);
      ev[6] = (hit && stop_mode_i) ? 1 : 0;
      clr = (wr_en && wr_sel == 2'd2) ? int'(wr_data) : 0;
      for (int i = 0; i < 7; i++)
        if (i != 2) m_flag[i] = (ev[i] != 0 || (m_flag[i] != 0 && ((clr >> i) & 1) == 0)) ? 1 : 0;
      if (hit) m_rw = m_byte % 2;
      if (st || sp) begin m_cnt = 0; m_first = st ? 1 : 0; end
      else if (rise && m_cnt < 9) begin
        if (m_cnt < 8) m_byte = (m_byte * 2 + sd) % 256;
        m_cnt++;
      end else if (fall && m_cnt == 9) begin m_cnt = 0; m_first = 0; end
      if (wr_en && wr_sel == 2'd0) m_ctrl = int'(wr_data) % 32;
      if (wr_en && wr_sel == 2'd1) m_own = int'(wr_data) % 128;
      m_scl = sc; m_sda = sd;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (int'(status_o) != model_status() || int'(irq_o) != model_irq()) begin
        fails++;
        $display("FAIL model R1 R8: status=%02h irq=%0d expected status=%02h irq=%0d",
                 status_o, irq_o, model_status(), model_irq());
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] mask, input logic [7:0] exp_s,
                     input int exp_irq);
    checks++;
    if ((status_o & mask) != (exp_s & mask) || (exp_irq >= 0 && int'(irq_o) != exp_irq)) begin
      fails++;
      $display("FAIL %s: status=%02h irq=%0d expected status&%02h=%02h irq=%0d",
               tag, status_o, irq_o, mask, exp_s & mask, exp_irq);
    end
  endtask

  task automatic step(input logic c, input logic d);
    @(posedge clk); #1; scl_i = c; sda_i = d;
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(posedge clk); #1; wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0;
    @(posedge clk); #2;
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    arb_lost_i = (which == 0); tmo_low_i = (which == 1); tmo_high_i = (which == 2);
    @(posedge clk); #1; arb_lost_i = 0; tmo_low_i = 0; tmo_high_i = 0;
    @(posedge clk); #2;
  endtask

  task automatic bus_start(); step(1, 1); step(1, 0); step(0, 0); endtask
  task automatic bus_stop();  step(0, 0); step(1, 0); step(1, 1); endtask
  task automatic bus_bit(input logic b); step(0, b); step(1, b); step(0, b); endtask
  task automatic bus_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 reset", 8'hFF, 8'h00, 0);

    wr(1, 8'h2A); wr(0, 8'h01);
    bus_start(); bus_byte(8'h54);
    chk("R4 R2 address hit before ack", 8'h07, 8'h02, 1);
    bus_bit(0);
    chk("R2 done at ninth fall", 8'h07, 8'h03, 1);
    wr(2, 8'h03);
    chk("R7 R8 clear and irq drop", 8'hFF, 8'h00, 0);

    wr(0, 8'h03);
    bus_byte(8'h55);
    chk("R3 fast ack done at eighth fall", 8'h03, 8'h01, 1);
    wr(2, 8'h01); bus_bit(0);
    chk("R3 no second done at ninth", 8'h03, 8'h00, 0);

    wr(0, 8'h01);
    bus_bit(1); bus_bit(0); bus_bit(1);
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    bus_byte(8'h55);
    chk("R11 R4 repeated start read address", 8'h07, 8'h06, 1);
    bus_bit(1);
    chk("R11 done after restart", 8'h07, 8'h07, 1);
    wr(2, 8'h07);
    chk("R7 direction bit not cleared", 8'hFF, 8'h04, 0);

    bus_stop(); bus_start(); bus_byte(8'h2A); bus_bit(0);
    chk("R6 mismatch keeps hit and rw", 8'h07, 8'h05, 1);
    wr(2, 8'h01);

    bus_stop(); bus_start(); bus_byte(8'h00); bus_bit(0);
    chk("R5 general call ignored when disabled", 8'h03, 8'h01, 1);
    wr(2, 8'h01); wr(0, 8'h05);
    bus_stop(); bus_start(); bus_byte(8'h00); bus_bit(0);
    chk("R5 general call accepted", 8'h07, 8'h03, 1);
    wr(2, 8'h03);

    pulse(0);
    chk("R12 arbitration lost", 8'hFF, 8'h08, 1);
    wr(2, 8'h08);
    pulse(1);
    chk("R12 low timeout", 8'hFF, 8'h10, 1);
    wr(2, 8'h10);
    pulse(2);
    chk("R9 high timeout masked", 8'hFF, 8'h20, 0);
    wr(0, 8'h15);
    chk("R9 high timeout enabled", 8'hFF, 8'h20, 1);
    wr(2, 8'h20);
    chk("R9 high timeout cleared", 8'hFF, 8'h00, 0);

    @(posedge clk); #1 stop_mode_i = 1'b1;
    bus_stop(); bus_start(); bus_byte(8'h54); bus_bit(0);
    chk("R10 wake flag on match in stop", 8'hFF, 8'h43, 1);
    wr(2, 8'h03);
    chk("R10 wake masked without enable", 8'hFF, 8'h40, 0);
    wr(0, 8'h1D);
    chk("R10 wake enabled", 8'hFF, 8'h40, 1);
    wr(2, 8'h40);
    bus_stop(); bus_start(); bus_byte(8'h2A); bus_bit(0);
    chk("R10 no wake on mismatch", 8'h42, 8'h00, -1);
    wr(2, 8'h01);
    @(posedge clk); #1 stop_mode_i = 1'b0;

    wr(0, 8'h00);
    @(posedge clk); #1 arb_lost_i = 1'b1;
    @(posedge clk); #1 wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h08;
    @(posedge clk); #1 arb_lost_i = 1'b0; wr_en = 1'b0;
    @(posedge clk); #2;
    chk("R12 set wins over clear, R8 irq off", 8'hFF, 8'h08, 0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule